// File: doc/BRIEF.md
# Pad Interrupt Routing Multiplexer

This block watches a wide bank of asynchronous pad signals and steers any eight of them onto eight interrupt lines that feed a downstream interrupt controller. Every line has its own pad selector and its own conditioning stage. The stage can invert the chosen pad and then present it either as a level or as a one-cycle event on a rising transition. The outputs are therefore always active-high, so a controller that accepts only high levels or rising edges can still serve sources that are active-low or fall.

Software sets up the block through four 32-bit registers. It writes them with a per-byte strobe, so a single lane can be changed without disturbing the others. It reads them back combinationally. Pads pass through a two-flop synchronizer before they are selected. Only the first `MAPPABLE` pad indices can be routed. A selector at or above that count silences its line, whatever the polarity setting. The filter-select register is only stored: it has no effect on the outputs.

Top module: `pad_irq_router`

## Requirements
- R1: After reset, all four registers read zero and every `irq_out` bit is 0.
- R2: The selector for line c is byte lane (c mod 4) of word 1 for c < 4, and of word 2 for c >= 4.
- R3: In word 0, bit c set puts line c in edge mode and bit 16+c set inverts line c. All other bits of word 0 read back as zero whatever was written.
- R4: In level mode, `irq_out[c]` equals the selected pad XOR the invert bit. It lags a pad change by exactly 3 clock edges.
- R5: In edge mode, a 0-to-1 transition of the conditioned pad yields a single-cycle `irq_out[c]` pulse, 3 edges after the pad changes.
- R6: An edge-mode line reacts to one direction only. With inversion set, a falling pad pulses and a rising pad gives nothing. Without inversion the roles swap.
- R7: A selector value of `MAPPABLE` or more holds `irq_out[c]` at 0, with or without inversion.
- R8: A write that touches line c's mode lane (lane 0 or 2 of word 0) or its selector lane masks any edge pulse for the first conditioned sample under the new setting. This also holds when a pad edge reaches the line in that same cycle.
- R9: A write updates only the byte lanes whose `cfg_wstrb` bit is set.
- R10: Word 3 (filter select, 4 bits per line) stores and reads back all 32 bits, and writing it leaves the outputs unchanged.
- R11: Lines are independent. Two lines that select the same pad in different modes each behave according to their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_PADS | Asynchronous pad levels |
| cfg_wr | input | 1 | Register write enable |
| cfg_addr | input | 2 | Word index: 0 mode, 1 selectors 0-3, 2 selectors 4-7, 3 filter |
| cfg_wdata | input | 32 | Write data |
| cfg_wstrb | input | 4 | Byte-lane write strobe |
| cfg_rdata | output | 32 | Combinational read data of word `cfg_addr` |
| irq_out | output | NUM_CH | Active-high interrupt lines |

## Verification
A configuration write and a pad transition can reach the same line in the same cycle. The write arms the mask for the next sample while the synchronized edge arrives for that same sample. The bench provokes this by raising a pad one cycle before it rewrites the line's selector, so that the second synchronizer stage and the register update share a clock edge. It then expects the line to stay low for several cycles, and it contrasts this with the unmasked edge case, which must pulse.

// File: rtl/pad_irq_pkg.sv
package pad_irq_pkg;
  localparam int SEL_W = 8;

  localparam logic [1:0] REG_MODE   = 2'd0;
  localparam logic [1:0] REG_SEL_LO = 2'd1;
  localparam logic [1:0] REG_SEL_HI = 2'd2;
  localparam logic [1:0] REG_FILT   = 2'd3;

  typedef struct packed {
    logic             edge_en;
    logic             inv;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pad_irq_regs.sv
module pad_irq_regs
  import pad_irq_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [1:0]             addr,
  input  logic [31:0]            wdata,
  input  logic [3:0]             wstrb,
  output logic [31:0]            rdata,
  output chan_cfg_t [NUM_CH-1:0] cfg,
  output logic [NUM_CH-1:0]      chg
);
  localparam logic [7:0] CH_MASK = 8'((1 << NUM_CH) - 1);

  logic [31:0] regs_q [4];

  function automatic logic [7:0] lane_mask(input logic [1:0] a, input int b);
    if (a == REG_MODE) return (b == 0 || b == 2) ? CH_MASK : 8'h00;
    return 8'hFF;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 4; r++) regs_q[r] <= '0;
    end else if (wr) begin
      for (int b = 0; b < 4; b++) begin
        if (wstrb[b]) regs_q[addr][b*8 +: 8] <= wdata[b*8 +: 8] & lane_mask(addr, b);
      end
    end
  end

  assign rdata = regs_q[addr];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
    localparam logic [1:0] SREG = (c < 4) ? REG_SEL_LO : REG_SEL_HI;
    localparam int         LANE = c % 4;

    assign cfg[c].edge_en = regs_q[REG_MODE][c];
    assign cfg[c].inv     = regs_q[REG_MODE][16 + c];
    assign cfg[c].sel     = regs_q[SREG][LANE*8 +: SEL_W];
    assign chg[c] = wr && (((addr == REG_MODE) && (wstrb[0] || wstrb[2])) ||
                           ((addr == SREG) && wstrb[LANE]));
  end
endmodule

// File: rtl/pad_irq_chan.sv
module pad_irq_chan
  import pad_irq_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int MAPPABLE = 133
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pads_s,
  input  chan_cfg_t           cfg,
  input  logic                chg,
  output logic                irq
);
  localparam int IDX_W = $clog2(NUM_PADS);

  logic in_range;
  logic active;
  logic prev_q;
  logic mask_q;

  assign in_range = 32'(cfg.sel) < MAPPABLE;
  assign active   = in_range & (pads_s[cfg.sel[IDX_W-1:0]] ^ cfg.inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      mask_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      prev_q <= active;
      mask_q <= chg;
      irq    <= cfg.edge_en ? (active & ~prev_q & ~mask_q) : active;
    end
  end
endmodule

// File: rtl/pad_irq_router.sv
module pad_irq_router
  import pad_irq_pkg::*;
#(
  parameter int NUM_PADS = 256,
  parameter int NUM_CH   = 8,
  parameter int MAPPABLE = 133
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  input  logic [3:0]          cfg_wstrb,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_CH-1:0]   irq_out
);
  logic [NUM_PADS-1:0]    pads_s;
  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]      chg_vec;

  pad_sync #(.W(NUM_PADS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pads_s)
  );

  pad_irq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .wstrb(cfg_wstrb), .rdata(cfg_rdata),
    .cfg(cfg), .chg(chg_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pad_irq_chan #(.NUM_PADS(NUM_PADS), .MAPPABLE(MAPPABLE)) u_chan (
      .clk(clk), .rst_n(rst_n), .pads_s(pads_s), .cfg(cfg[c]),
      .chg(chg_vec[c]), .irq(irq_out[c])
    );
  end
endmodule

// File: rtl/pad_irq_router_chk.sv
module pad_irq_router_chk
  import pad_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int MAPPABLE = 133
) (
  input logic                   clk,
  input logic                   rst_n,
  input chan_cfg_t [NUM_CH-1:0] cfg,
  input logic [NUM_CH-1:0]      chg_vec,
  input logic [NUM_CH-1:0]      irq_out,
  input logic                   cfg_wr,
  input logic [1:0]             cfg_addr,
  input logic [31:0]            cfg_wdata,
  input logic [3:0]             cfg_wstrb,
  input logic [31:0]            cfg_rdata
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic bad;
    assign bad = 32'(cfg[c].sel) >= MAPPABLE;

    AST_BAD_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> !irq_out[c]); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out[c] && cfg[c].edge_en && $past(cfg[c].edge_en)) |=> !irq_out[c]); // R5

    AST_CFG_MASKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_vec[c] ##1 cfg[c].edge_en) |=> !irq_out[c]); // R8
  end

  AST_FILT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == REG_FILT && cfg_wstrb == 4'hF) ##1 (cfg_addr == REG_FILT)
      |-> cfg_rdata == $past(cfg_wdata)); // R10
endmodule

bind pad_irq_router pad_irq_router_chk #(.NUM_CH(NUM_CH), .MAPPABLE(MAPPABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .chg_vec(chg_vec), .irq_out(irq_out),
  .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_wstrb(cfg_wstrb), .cfg_rdata(cfg_rdata)
);

// File: tb/test_pad_irq_router.sv
module test_pad_irq_router;
  localparam int NP = 256;
  localparam int NC = 8;
  localparam int MP = 133;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pad_in = '0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [3:0]    cfg_wstrb = '0;
  logic [31:0]   cfg_rdata;
  logic [NC-1:0] irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  pad_irq_router #(.NUM_PADS(NP), .NUM_CH(NC), .MAPPABLE(MP)) i_pad_irq_router (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wstrb(cfg_wstrb),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_wstrb = s;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wstrb = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic watch(input int n, input int c, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (irq_out[c]) hits++;
    end
  endtask

  task automatic clear_all();
    for (int r = 0; r < 4; r++) wr(2'(r), 32'h0, 4'hF);
    pad_in = '0;
    tick(5);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq_out), 32'h0);
  endtask

  task automatic t_layout();
    wr(2'd1, {8'd23, 8'd22, 8'd21, 8'd20}, 4'hF);
    wr(2'd2, {8'd27, 8'd26, 8'd25, 8'd24}, 4'hF);
    tick(4);
    pad_in[22] = 1'b1;
    tick(3);
    chk("R2 pad22 on line 2", 32'(irq_out), 32'h04);
    pad_in[22] = 1'b0; pad_in[25] = 1'b1;
    tick(3);
    chk("R2 pad25 on line 5", 32'(irq_out), 32'h20);
    clear_all();
  endtask

  task automatic t_level();
    wr(2'd1, 32'd10, 4'h1);
    tick(4);
    pad_in[10] = 1'b1;
    tick(2);
    chk("R4 not yet after 2 edges", 32'(irq_out[0]), 32'h0);
    tick(1);
    chk("R4 high after 3 edges", 32'(irq_out[0]), 32'h1);
    wr(2'd0, 32'h0001_0000, 4'h4);
    tick(3);
    chk("R4 inverted high pad gives 0", 32'(irq_out[0]), 32'h0);
    pad_in[10] = 1'b0;
    tick(3);
    chk("R4 inverted low pad gives 1", 32'(irq_out[0]), 32'h1);
    clear_all();
  endtask

  task automatic t_edge();
    int hits;
    wr(2'd1, 32'd30 << 8, 4'h2);
    wr(2'd0, 32'h0000_0002, 4'h1);
    tick(4);
    pad_in[30] = 1'b1;
    tick(3);
    chk("R5 rising pulse present", 32'(irq_out[1]), 32'h1);
    tick(1);
    chk("R5 pulse lasts one cycle", 32'(irq_out[1]), 32'h0);
    pad_in[30] = 1'b0;
    watch(6, 1, hits);
    chk("R6 falling ignored without invert", 32'(hits), 32'd0);
    wr(2'd0, 32'h0002_0002, 4'h5);
    tick(4);
    pad_in[30] = 1'b1;
    watch(6, 1, hits);
    chk("R6 rising ignored with invert", 32'(hits), 32'd0);
    pad_in[30] = 1'b0;
    watch(6, 1, hits);
    chk("R6 falling gives one pulse with invert", 32'(hits), 32'd1);
    clear_all();
  endtask

  task automatic t_bad_sel();
    wr(2'd1, 32'd200 << 16, 4'h4);
    wr(2'd0, 32'h0004_0000, 4'h4);
    pad_in[200] = 1'b1;
    tick(5);
    chk("R7 out-of-range inverted high pad", 32'(irq_out[2]), 32'h0);
    pad_in[200] = 1'b0;
    tick(5);
    chk("R7 out-of-range inverted low pad", 32'(irq_out[2]), 32'h0);
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd1, 32'(MP - 1) << 16, 4'h4);
    pad_in[MP-1] = 1'b1;
    tick(4);
    chk("R7 last mappable index routes", 32'(irq_out[2]), 32'h1);
    pad_in[MP] = 1'b1;
    wr(2'd1, 32'(MP) << 16, 4'h4);
    tick(3);
    chk("R7 first unmappable index silent", 32'(irq_out[2]), 32'h0);
    clear_all();
  endtask

  task automatic t_cfg_mask();
    int hits;
    wr(2'd1, 32'd7, 4'h1);
    tick(4);
    wr(2'd0, 32'h0001_0001, 4'h5);
    watch(6, 0, hits);
    chk("R8 no pulse from polarity write", 32'(hits), 32'd0);
    clear_all();
  endtask

  task automatic t_same_cycle();
    int hits;
    wr(2'd1, 32'd7, 4'h1);
    wr(2'd0, 32'h1, 4'h1);
    tick(4);
    pad_in[7] = 1'b1;
    tick(1);
    wr(2'd1, 32'd7, 4'h1);
    watch(6, 0, hits);
    chk("R8 edge coinciding with write masked", 32'(hits), 32'd0);
    clear_all();
  endtask

  task automatic t_strobe();
    logic [31:0] d;
    wr(2'd1, 32'h1122_3344, 4'hF);
    wr(2'd1, 32'hAABB_CCDD, 4'b0101);
    rd(2'd1, d);
    chk("R9 only strobed lanes change", d, 32'h11BB_33DD);
    wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    rd(2'd0, d);
    chk("R3 reserved mode bits read zero", d, 32'h00FF_00FF);
    clear_all();
  endtask

  task automatic t_filter();
    logic [31:0] d;
    wr(2'd1, 32'd50, 4'h1);
    pad_in[50] = 1'b1;
    tick(4);
    wr(2'd3, 32'hDEAD_BEEF, 4'hF);
    rd(2'd3, d);
    chk("R10 filter readback", d, 32'hDEAD_BEEF);
    tick(3);
    chk("R10 filter write leaves output", 32'(irq_out), 32'h01);
    clear_all();
  endtask

  task automatic t_indep();
    int hits3;
    wr(2'd1, 32'd40 << 24, 4'h8);
    wr(2'd2, 32'd40, 4'h1);
    wr(2'd0, 32'h10, 4'h1);
    tick(4);
    pad_in[40] = 1'b1;
    tick(3);
    chk("R11 both lines see the edge", 32'(irq_out[4:3]), 32'h3);
    hits3 = 0;
    for (int i = 0; i < 4; i++) begin
      tick(1);
      if (irq_out[3]) hits3++;
      chk("R11 edge line quiet after pulse", 32'(irq_out[4]), 32'h0);
    end
    chk("R11 level line holds", 32'(hits3), 32'd4);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_layout();
    t_level();
    t_edge();
    t_bad_sel();
    t_cfg_mask();
    t_same_cycle();
    t_strobe();
    t_filter();
    t_indep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule